// File: doc/BRIEF.md
# Channel Symbol to Stochastic Stream Converter

This block turns quantized soft channel symbols into Bernoulli bit streams for a bit-serial iterative decoder. Each symbol is a 6-bit two's-complement value. It is written into one lane through a strobe and an index, one lane per clock. A fixed scaling table maps the symbol's magnitude to a 7-bit probability, and the lane stores that probability together with the symbol's sign. The value then stays put until the lane is written again.

While the run enable is high, every lane compares its stored probability against a shared 7-bit random number on each clock. The result goes to a registered output bit. The output is inverted for negative symbols, so the table only needs entries for the non-negative half. The random number comes from two 10-bit LFSRs. Bits from the two registers are XORed, and both registers step once per enabled cycle. The streams feed the variable nodes of the decoder, one stream per lane.

Top module: `stoch_stream_conv`

## Requirements
- R1: A synchronous active-low reset clears every lane's probability, sign and output bit to 0. It loads LFSR A with 10'h2A5 and LFSR B with 10'h13C.
- R2: For a non-negative symbol s (0..31), the lane stores probability 64 + 2*s, read as a 7-bit value over 128. Its stream bit is then 1 exactly when that value is greater than the current random number.
- R3: The symbol -32 has magnitude 32, which is out of range. It is treated as magnitude 31 (probability 126).
- R4: A negative symbol uses the table entry of its magnitude, and every stream bit it produces is the bit-wise inverse of the comparison result.
- R5: The comparison is strict: equal values give 0 before any inversion. The result is registered, so it appears on stream_out after the clock edge at which run_en was sampled high.
- R6: LFSR A shifts left with new bit 0 = bit9 XOR bit6, and LFSR B shifts left with new bit 0 = bit9 XOR bit2. Random bit i (i = 0..6) is A[i] XOR B[(i+3) mod 10]. Both LFSRs step once on each clock edge at which run_en is high, after that edge's comparison has used their old value.
- R7: While run_en is low, the stream outputs and both LFSRs keep their values.
- R8: When sym_load is high and sym_index is below the lane count (5), only the indexed lane takes the new probability and sign. An index of 5, 6 or 7 changes no lane.
- R9: A lane written at the same edge at which it is compared uses its old probability and sign for that edge's output bit, and the new ones from the next enabled edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_load | input | 1 | Write strobe for one lane's symbol |
| sym_index | input | 3 | Lane addressed by the write |
| sym_value | input | 6 | Two's-complement received symbol |
| run_en | input | 1 | Lets the streams and random engine advance |
| stream_out | output | 5 | One stochastic bit per lane |

## Verification
The checker module checks four behaviours on every cycle: the cleared outputs just after reset, that neither LFSR ever reaches zero, that the LFSR state changes on each enabled cycle, and that outputs and LFSRs hold while disabled. The following only show up in the bench's scenarios, where a behavioural model predicts every lane's bit on every clock:
- the table values and the clamp of -32;
- the inversion for negative symbols;
- the exact random bit mapping;
- index decoding, including ignored indexes;
- the ordering of a write against the comparison at the same edge.

// File: rtl/stoch_pkg.sv
// Package: shared constants and the scaling-table generator for the
// stochastic stream converter. Assumes probabilities are unsigned fractions
// over 2**PROB_W and that the table covers non-negative magnitudes only.
package stoch_pkg;

    // Value stored for magnitude k: half scale plus a linear ramp that stays
    // below full scale for every magnitude the symbol width allows.
    function automatic int unsigned half_prob(int unsigned k, int prob_w, int sym_w);
        int unsigned step;
        step = 1 << (prob_w - sym_w);
        return (1 << (prob_w - 1)) + k * step;
    endfunction

endpackage

// File: rtl/stoch_scale_lut.sv
// Scaling table for half the symbol range. Maps a two's-complement symbol
// to (probability of its clamped magnitude, sign). Assumes PROB_W > SYM_W so
// every computed entry fits. Purely combinational.
module stoch_scale_lut #(
    parameter int SYM_W  = 6,
    parameter int PROB_W = 7
) (
    input  logic [SYM_W-1:0]  sym,
    output logic [PROB_W-1:0] prob,
    output logic              neg
);
    import stoch_pkg::*;

    localparam int MAG_W = SYM_W - 1;
    localparam int DEPTH = 1 << MAG_W;

    logic [PROB_W-1:0] half_tab [DEPTH];
    logic [SYM_W-1:0]  mag_full;
    logic [MAG_W-1:0]  mag;

    // Table contents computed from the package function, one entry per magnitude.
    for (genvar k = 0; k < DEPTH; k++) begin : g_tab
        assign half_tab[k] = PROB_W'(half_prob(k, PROB_W, SYM_W));
    end

    // Magnitude with saturation of the most negative code.
    always_comb begin
        neg      = sym[SYM_W-1];
        mag_full = neg ? (~sym + 1'b1) : sym;
        mag      = mag_full[SYM_W-1] ? {MAG_W{1'b1}} : mag_full[MAG_W-1:0];
        prob     = half_tab[mag];
    end
endmodule

// File: rtl/stoch_rng.sv
// Shared random engine: two Fibonacci LFSRs stepped together; the random
// word is formed by XORing bit i of A with bit (i+ROT) mod W of B.
// Assumes both tap choices give primitive polynomials and nonzero seeds.
module stoch_rng #(
    parameter int              LFSR_W = 10,
    parameter int              OUT_W  = 7,
    parameter int              TAP_A  = 6,
    parameter int              TAP_B  = 2,
    parameter int              ROT    = 3,
    parameter logic [LFSR_W-1:0] SEED_A = 10'h2A5,
    parameter logic [LFSR_W-1:0] SEED_B = 10'h13C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [LFSR_W-1:0] state_a,
    output logic [LFSR_W-1:0] state_b,
    output logic [OUT_W-1:0]  rnd
);
    // Advance both registers once per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_a <= SEED_A;
            state_b <= SEED_B;
        end else if (step) begin
            state_a <= {state_a[LFSR_W-2:0], state_a[LFSR_W-1] ^ state_a[TAP_A]};
            state_b <= {state_b[LFSR_W-2:0], state_b[LFSR_W-1] ^ state_b[TAP_B]};
        end
    end

    // Random word bits from a rotated pairing of the two registers.
    for (genvar i = 0; i < OUT_W; i++) begin : g_mix
        localparam int BI = (i + ROT) % LFSR_W;
        assign rnd[i] = state_a[i] ^ state_b[BI];
    end
endmodule

// File: rtl/stoch_lane.sv
// One variable-node lane: holds a probability and sign, and on each enabled
// cycle registers (prob > rnd) XOR sign. A write updates the held value
// for later cycles; the same-edge comparison uses the old value.
module stoch_lane #(
    parameter int PROB_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PROB_W-1:0] wr_prob,
    input  logic              wr_neg,
    input  logic              run_en,
    input  logic [PROB_W-1:0] rnd,
    output logic              bit_out
);
    logic [PROB_W-1:0] prob_q;
    logic              neg_q;

    // Held probability/sign and the registered stream bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prob_q  <= '0;
            neg_q   <= 1'b0;
            bit_out <= 1'b0;
        end else begin
            if (run_en)
                bit_out <= (prob_q > rnd) ^ neg_q;
            if (wr_en) begin
                prob_q <= wr_prob;
                neg_q  <= wr_neg;
            end
        end
    end
endmodule

// File: rtl/stoch_stream_conv.sv
// Top: serial symbol loading into NUM_VN lanes through one scaling table,
// one shared random engine, one comparator per lane. Assumes the index
// width covers NUM_VN; indexes at or above NUM_VN are dropped.
module stoch_stream_conv #(
    parameter int NUM_VN = 5,
    parameter int SYM_W  = 6,
    parameter int PROB_W = 7,
    parameter int LFSR_W = 10,
    parameter int IDX_W  = (NUM_VN > 1) ? $clog2(NUM_VN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_load,
    input  logic [IDX_W-1:0]  sym_index,
    input  logic [SYM_W-1:0]  sym_value,
    input  logic              run_en,
    output logic [NUM_VN-1:0] stream_out
);
    logic [PROB_W-1:0] lut_prob;
    logic              lut_neg;
    logic [PROB_W-1:0] rnd_word;
    logic [LFSR_W-1:0] rng_a;
    logic [LFSR_W-1:0] rng_b;

    stoch_scale_lut #(.SYM_W(SYM_W), .PROB_W(PROB_W)) u_lut (
        .sym  (sym_value),
        .prob (lut_prob),
        .neg  (lut_neg)
    );

    stoch_rng #(.LFSR_W(LFSR_W), .OUT_W(PROB_W)) u_rng (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (run_en),
        .state_a (rng_a),
        .state_b (rng_b),
        .rnd     (rnd_word)
    );

    // One lane per variable node, written when its index is addressed.
    for (genvar v = 0; v < NUM_VN; v++) begin : g_lane
        logic wr_hit;
        assign wr_hit = sym_load && (sym_index == IDX_W'(v));
        stoch_lane #(.PROB_W(PROB_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_hit),
            .wr_prob (lut_prob),
            .wr_neg  (lut_neg),
            .run_en  (run_en),
            .rnd     (rnd_word),
            .bit_out (stream_out[v])
        );
    end
endmodule

// File: rtl/stoch_stream_conv_chk.sv
// Checker for the converter: reset clearing, random-engine liveness and
// hold behaviour while disabled. Attached to the top with bind below.
module stoch_stream_conv_chk #(
    parameter int NUM_VN = 5,
    parameter int LFSR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic [NUM_VN-1:0] stream_out,
    input logic [LFSR_W-1:0] rng_a,
    input logic [LFSR_W-1:0] rng_b
);
    // R1: first cycle out of reset shows cleared streams.
    a_r1_reset_clear: assert property (@(posedge clk)
        $rose(rst_n) |-> (stream_out == '0));

    // R6: neither register may fall into the all-zero lock state.
    a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (rng_a != '0) && (rng_b != '0));

    // R6: an enabled cycle always moves the random engine.
    a_r6_lfsr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> (rng_a != $past(rng_a)) && (rng_b != $past(rng_b)));

    // R7: disabled cycles freeze streams and engine.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(stream_out) && $stable(rng_a) && $stable(rng_b));
endmodule

bind stoch_stream_conv stoch_stream_conv_chk #(
    .NUM_VN (NUM_VN),
    .LFSR_W (LFSR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .stream_out (stream_out),
    .rng_a      (rng_a),
    .rng_b      (rng_b)
);

// File: tb/tb_stoch_stream_conv.sv
`timescale 1ns/1ps
module tb_stoch_stream_conv;
    localparam int NV = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sym_load = 1'b0;
    logic [2:0]    sym_index = '0;
    logic [5:0]    sym_value = '0;
    logic          run_en = 1'b0;
    logic [NV-1:0] stream_out;

    int  m_p   [NV];
    bit  m_neg [NV];
    bit  m_out [NV];
    int  la, lb;
    int  n_vec = 0;
    int  n_err = 0;
    bit  finished = 1'b0;

    stoch_stream_conv dut (
        .clk (clk), .rst_n (rst_n), .sym_load (sym_load), .sym_index (sym_index),
        .sym_value (sym_value), .run_en (run_en), .stream_out (stream_out)
    );

    always #2.5 clk = ~clk;

    function automatic int exp_prob(int s);
        int mag;
        mag = (s < 0) ? -s : s;
        if (mag > 31) mag = 31;
        return 64 + 2 * mag;
    endfunction

    function automatic int cur_rnd();
        int r = 0;
        for (int i = 0; i < 7; i++)
            r += (((la >> i) ^ (lb >> ((i + 3) % 10))) & 1) << i;
        return r;
    endfunction

    task automatic model_reset();
        for (int v = 0; v < NV; v++) begin
            m_p[v] = 0; m_neg[v] = 0; m_out[v] = 0;
        end
        la = 'h2A5; lb = 'h13C;
    endtask

    task automatic compare(string req);
        for (int v = 0; v < NV; v++) begin
            n_vec++;
            if (stream_out[v] !== m_out[v]) begin
                n_err++;
                $display("FAIL %s lane %0d: actual %b expected %b", req, v, stream_out[v], m_out[v]);
            end
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rising
    // edge, compare at the next falling edge.
    task automatic cycle(bit ld, int idx, int sym, bit en, string req);
        int r;
        sym_load  = ld;
        sym_index = 3'(idx);
        sym_value = 6'(sym);
        run_en    = en;
        @(posedge clk);
        if (en) begin
            r = cur_rnd();
            for (int v = 0; v < NV; v++)
                m_out[v] = (m_p[v] > r) ^ m_neg[v];
            la = ((la << 1) | (((la >> 9) ^ (la >> 6)) & 1)) & 1023;
            lb = ((lb << 1) | (((lb >> 9) ^ (lb >> 2)) & 1)) & 1023;
        end
        if (ld && idx < NV) begin
            m_p[idx]   = exp_prob(sym);
            m_neg[idx] = (sym < 0);
        end
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        int syms [NV];
        syms = '{31, -32, 0, -1, 17};
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");                                  // R1 reset state
        // R2 R3 R4 R8: load every lane with run disabled (R7: outputs stay 0)
        for (int v = 0; v < NV; v++) cycle(1'b1, v, syms[v], 1'b0, "R8");
        // R2 R3 R4 R5 R6: free run
        for (int k = 0; k < 150; k++) cycle(1'b0, 0, 0, 1'b1, "R6");
        // R7: alternating enable
        for (int k = 0; k < 60; k++) cycle(1'b0, 0, 0, k[0], "R7");
        // R8: out-of-range indexes while running
        for (int k = 0; k < 30; k++) cycle(1'b1, 5 + (k % 3), -20 + k, 1'b1, "R8");
        // R9: rewrite lane 2 on every enabled cycle
        for (int k = 0; k < 40; k++) cycle(1'b1, 2, (k * 7) % 64 - 32, 1'b1, "R9");
        // R3 R4: extreme values across lanes
        for (int v = 0; v < NV; v++) cycle(1'b1, v, (v % 2) ? -32 : 31, 1'b1, "R3");
        for (int k = 0; k < 80; k++) cycle(1'b0, 0, 0, 1'b1, "R4");
        // Mixed traffic
        for (int k = 0; k < 400; k++)
            cycle(1'($urandom_range(0, 1)), $urandom_range(0, 7),
                  $signed($urandom_range(0, 63)) - 32, 1'($urandom_range(0, 3) != 0), "R2");
        // R1: reset again mid-stream
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        compare("R1");
        for (int k = 0; k < 20; k++) cycle(1'b0, 0, 0, 1'b1, "R1");
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule